// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter with Ripple Grant Chains

This block decides which device may use a shared bus. The devices sit in several priority levels. Each level has a short chain of device slots. Within a level, the requests of all slots merge into one level request, so the central controller only learns that some device on that level wants the bus. It does not learn which one. When the bus is free, the controller picks the most urgent level that has a request and drives that level's grant into the head of its chain. The grant then ripples down the slots. The first slot that is requesting keeps the grant and blocks it from reaching the slots behind it. A slot that is not requesting lets the grant pass on to the next slot.

The winning slot is registered as the owner and keeps the bus for as long as it holds its request. No later request can take the bus away from it, whatever that request's level or chain position. When the owner drops its request, the grant is removed at the next clock edge. The controller then spends exactly one idle cycle before it arbitrates again. Level 0 is the most urgent level. Slot 0 of each chain sits nearest the controller.

Top module: `daisy_arbiter`

## Requirements
- R1: After reset is applied, `slotGrant` and `levelGrant` are all zero.
- R2: When requests are pending on several levels while the bus is free, the grant goes to a slot of the level with the lowest index. Level 0 is the most urgent level.
- R3: When several slots of the chosen level request at once, the slot with the lowest position in the chain wins. Slot s of level l is bit `l*SLOTS + s` of `slotReq` and `slotGrant`.
- R4: At most one bit of `slotGrant` is set in any cycle.
- R5: A request applied while the arbiter is idle is granted at the next rising clock edge.
- R6: While the owner keeps its request high, its grant stays unchanged. This holds even when a slot on a more urgent level, or a slot nearer the arbiter on the same level, starts requesting.
- R7: When the owner drops its request, all grants are zero after the next edge. A new grant appears no earlier than the edge after that.
- R8: While no slot requests and no slot owns the bus, no grant is asserted.
- R9: Bit l of `levelGrant` is set exactly when the current owner belongs to level l.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| slotReq | input | LEVELS*SLOTS | Request of each slot; bit l*SLOTS+s is slot s of level l |
| slotGrant | output | LEVELS*SLOTS | One-hot grant to the owning slot |
| levelGrant | output | LEVELS | Grant line of each level; set for the owner's level |

## Verification
On every cycle, the assertions check four things: the grant stays one-hot, an owner that still requests keeps an unchanged grant, a dropped request clears the grant one edge later and is followed by an idle cycle, and the slot captured on a grant was in fact requesting. Other behaviours depend on what the arbiter chose among competing requests, so only the bench's directed scenarios can show them. These are the choice of the most urgent level, the win of the nearest slot in a chain, non-preemption against a specific newcomer, and the order in which waiting requesters are served after each release.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OWN  = 1'b1
  } arbState_e;

  typedef struct packed {
    logic capture;  // latch the rippled winner as the new owner
    logic drop;     // clear the owner
  } arbStrobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVELS-1:0] levelReq,
  input  logic              ownerHeld,
  output arbStrobe_t        strb,
  output logic [LEVELS-1:0] levelPick
);
  arbState_e stateQ, stateD;
  logic [LEVELS-1:0] lowestReq;

  // Most urgent level (lowest index) among the merged level requests.
  always_comb begin
    logic found;
    found = 1'b0;
    lowestReq = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (levelReq[l] && !found) begin
        lowestReq[l] = 1'b1;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    stateD = stateQ;
    strb = '0;
    levelPick = '0;
    case (stateQ)
      ST_IDLE: begin
        levelPick = lowestReq;
        if (|levelReq) begin
          strb.capture = 1'b1;
          stateD = ST_OWN;
        end
      end
      ST_OWN: begin
        if (!ownerHeld) begin
          strb.drop = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  a_r2_pick_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(levelPick));

  a_r2_pick_requested: assert property (@(posedge clk) disable iff (!rstN)
    (|levelPick) |-> (|(levelPick & levelReq)));

  a_r7_idle_after_drop: assert property (@(posedge clk) disable iff (!rstN)
    strb.drop |=> (stateQ == ST_IDLE && !strb.drop));
endmodule

// File: rtl/arb_chain_dp.sv
module arb_chain_dp
  import arb_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LEVELS*SLOTS-1:0] slotReq,
  input  arbStrobe_t              strb,
  input  logic [LEVELS-1:0]       levelPick,
  output logic [LEVELS-1:0]       levelReq,
  output logic                    ownerHeld,
  output logic [LEVELS*SLOTS-1:0] slotGrant,
  output logic [LEVELS-1:0]       levelGrant
);
  localparam int TOTAL = LEVELS * SLOTS;

  logic [TOTAL-1:0] take;
  logic [TOTAL-1:0] ownerQ;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    logic [SLOTS-1:0] passIn;
    assign levelReq[l]   = |slotReq[l*SLOTS +: SLOTS];
    assign levelGrant[l] = |ownerQ[l*SLOTS +: SLOTS];
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s == 0) begin : g_head
        assign passIn[s] = levelPick[l];
      end else begin : g_link
        // A requesting slot upstream keeps the grant; an idle one forwards it.
        assign passIn[s] = passIn[s-1] & ~slotReq[l*SLOTS + s - 1];
      end
      assign take[l*SLOTS + s] = passIn[s] & slotReq[l*SLOTS + s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ownerQ <= '0;
    else if (strb.drop)    ownerQ <= '0;
    else if (strb.capture) ownerQ <= take;
  end

  assign ownerHeld = |(ownerQ & slotReq);
  assign slotGrant = ownerQ;

  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ownerQ));

  a_r6_owner_kept: assert property (@(posedge clk) disable iff (!rstN)
    ((|ownerQ) && ownerHeld) |=> (ownerQ == $past(ownerQ)));

  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((|ownerQ) && !ownerHeld) |=> (ownerQ == '0));

  a_r5_capture_grants: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (|ownerQ));

  a_r3_winner_requested: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (|(ownerQ & $past(slotReq))));
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter
  import arb_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LEVELS*SLOTS-1:0] slotReq,
  output logic [LEVELS*SLOTS-1:0] slotGrant,
  output logic [LEVELS-1:0]       levelGrant
);
  arbStrobe_t        strb;
  logic [LEVELS-1:0] levelPick;
  logic [LEVELS-1:0] levelReq;
  logic              ownerHeld;

  arb_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .levelReq  (levelReq),
    .ownerHeld (ownerHeld),
    .strb      (strb),
    .levelPick (levelPick)
  );

  arb_chain_dp #(.LEVELS(LEVELS), .SLOTS(SLOTS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .slotReq    (slotReq),
    .strb       (strb),
    .levelPick  (levelPick),
    .levelReq   (levelReq),
    .ownerHeld  (ownerHeld),
    .slotGrant  (slotGrant),
    .levelGrant (levelGrant)
  );
endmodule

// File: tb/daisy_arbiter_bench.sv
module daisy_arbiter_bench;
  localparam int LEVELS = 4;
  localparam int SLOTS  = 4;
  localparam int TOTAL  = LEVELS * SLOTS;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [TOTAL-1:0] slotReq = '0;
  logic [TOTAL-1:0] slotGrant;
  logic [LEVELS-1:0] levelGrant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  daisy_arbiter #(.LEVELS(LEVELS), .SLOTS(SLOTS)) u_daisy_arbiter (
    .clk(clk), .rstN(rstN), .slotReq(slotReq),
    .slotGrant(slotGrant), .levelGrant(levelGrant)
  );

  function automatic logic [TOTAL-1:0] bitOf(int l, int s);
    logic [TOTAL-1:0] v;
    v = '0;
    v[l*SLOTS + s] = 1'b1;
    return v;
  endfunction

  function automatic logic [LEVELS-1:0] levelsOf(logic [TOTAL-1:0] g);
    logic [LEVELS-1:0] r;
    r = '0;
    for (int l = 0; l < LEVELS; l++) r[l] = |g[l*SLOTS +: SLOTS];
    return r;
  endfunction

  // Advance one edge; inputs change 1 ns after it, outputs are stable then.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic checkGrant(string tag, logic [TOTAL-1:0] expG);
    checks++;
    if (slotGrant !== expG) begin
      fails++;
      $display("FAIL %s slotGrant actual=%b expected=%b", tag, slotGrant, expG);
    end
    checks++;
    if (levelGrant !== levelsOf(expG)) begin
      fails++;
      $display("FAIL %s R9 levelGrant actual=%b expected=%b", tag, levelGrant, levelsOf(expG));
    end
    checks++;
    if ($countones(slotGrant) > 1) begin
      fails++;
      $display("FAIL %s R4 grant count actual=%0d expected<=1", tag, $countones(slotGrant));
    end
  endtask

  task automatic testReset();
    checkGrant("R1 reset", '0);
    step(); step();
    checkGrant("R8 no request", '0);
  endtask

  task automatic testSingle();
    slotReq = bitOf(2, 3);
    step();
    checkGrant("R5 single grant", bitOf(2, 3));
    slotReq = '0;
    step();
    checkGrant("R7 release", '0);
    step();
    checkGrant("R8 quiet after release", '0);
  endtask

  task automatic testLevels();
    slotReq = bitOf(3, 0) | bitOf(1, 2) | bitOf(2, 1);
    step();
    checkGrant("R2 level priority", bitOf(1, 2));
    slotReq = '0;
    step(); step();
  endtask

  task automatic testChain();
    slotReq = bitOf(2, 3) | bitOf(2, 1) | bitOf(2, 2);
    step();
    checkGrant("R3 nearest slot", bitOf(2, 1));
    slotReq = bitOf(2, 3) | bitOf(2, 2);
    step();
    checkGrant("R7 gap after owner drop", '0);
    step();
    checkGrant("R3 next in chain", bitOf(2, 2));
    slotReq = '0;
    step(); step();
  endtask

  task automatic testNoPreempt();
    slotReq = bitOf(3, 2);
    step();
    checkGrant("R5 low level grant", bitOf(3, 2));
    slotReq = bitOf(3, 2) | bitOf(0, 0) | bitOf(3, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      checkGrant("R6 held against urgent/nearer", bitOf(3, 2));
    end
    slotReq = bitOf(0, 0) | bitOf(3, 0);
    step();
    checkGrant("R7 one idle cycle", '0);
    step();
    checkGrant("R2 urgent served next", bitOf(0, 0));
    slotReq = bitOf(3, 0);
    step();
    checkGrant("R7 gap before next", '0);
    step();
    checkGrant("R5 waiting slot served", bitOf(3, 0));
    slotReq = '0;
    step(); step();
  endtask

  task automatic testInChainHold();
    slotReq = bitOf(1, 3);
    step();
    checkGrant("R5 far slot", bitOf(1, 3));
    slotReq = bitOf(1, 3) | bitOf(1, 0);
    step();
    checkGrant("R6 nearer slot waits", bitOf(1, 3));
    step();
    checkGrant("R6 nearer slot still waits", bitOf(1, 3));
    slotReq = '0;
    step();
    checkGrant("R7 both dropped", '0);
    step();
    checkGrant("R8 idle", '0);
  endtask

  task automatic testMidReset();
    slotReq = bitOf(0, 1);
    step();
    checkGrant("R5 pre reset grant", bitOf(0, 1));
    rstN = 1'b0;
    #1;
    checkGrant("R1 reset clears owner", '0);
    slotReq = '0;
    step();
    rstN = 1'b1;
    step();
    checkGrant("R8 after reset", '0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testSingle();
    testLevels();
    testChain();
    testNoPreempt();
    testInChainHold();
    testMidReset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule